// File: doc/BRIEF.md
# Programmable Threshold Switch with Hysteresis

This block turns a stream of signed magnetic field samples into a single switch output. Each valid sample is compared against an operate threshold set by a signed 7-bit code. A release threshold sits a fixed distance below the operate threshold. A field at or above the operate threshold pulls the output low, which means the target is present. A field below the release threshold lets the output return high, which means a gap or no target. A field between the two thresholds leaves the output where it was. The output is active low, in the way an open-drain driver would be wired.

The operate threshold equals a base value plus the signed code times a step size. The code is a 7-bit magnitude plus a sign bit. Moving the code moves both thresholds together, and the gap between them stays the same. Samples arrive with a one-cycle valid strobe at a fixed rate, nominally 250 kHz.

When power comes up, the block holds its output high for a fixed number of clock cycles while the front end settles. Only after that delay may a sample decide the output. The first decision is taken from the sample alone. A power-good input that falls forces the block back to this power-on state.

Top module: `trip_switch`

## Requirements
- R1: Once tracking, a valid sample with field >= operate threshold drives `out_level` to 0 on the clock edge that takes the sample.
- R2: A valid sample with field < release threshold drives `out_level` to 1 on the clock edge that takes the sample.
- R3: Once tracking, a valid sample with release <= field < operate leaves `out_level` unchanged.
- R4: Operate threshold = BASE + c*STEP, where c = +`code_mag` when `code_neg` = 0 and c = -`code_mag` when `code_neg` = 1. `code_mag` is 7 bits wide, so c spans -127..+127, and a negative zero equals zero.
- R5: Release threshold = operate threshold - HYST for every code.
- R6: After reset, or after `pwr_good` rises, `out_level` stays 1 and every sample is ignored until `pwr_good` has been high for SETTLE_CYC clock edges. The first sample that can be taken is the one presented at edge SETTLE_CYC+1.
- R7: The first sample taken after the settle delay sets the output directly: 0 if field >= operate, and 1 otherwise, including a field that lies between the two thresholds.
- R8: `pwr_good` low forces `out_level` to 1 at the next edge and restarts the settle delay.
- R9: A change of the code is used by the very next valid sample.
- R10: While `rst_n` is low (synchronous), `out_level` is 1.
- R11: When `smp_vld` is 0, the field input has no effect on `out_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply valid; low returns the block to the power-on state |
| smp_vld | input | 1 | One-cycle strobe marking a valid field sample |
| smp_field | input | FW (16) | Signed field sample, two's complement |
| code_mag | input | 7 | Switch-point code magnitude |
| code_neg | input | 1 | Switch-point code sign (1 = negative) |
| out_level | output | 1 | Switch output, 0 = target present |

## Verification
The assertions check on every cycle that a sample at or above operate gives a low output and a sample below release gives a high one. They also check that an in-band sample or a cycle with no strobe keeps the output unchanged, that loss of power-good gives a high output, and that the output is high throughout the settle window. The constant gap between the two thresholds is checked as well. The exact boundary cycles can only be shown by the bench scenarios: the last ignored sample and the first taken one. The same holds for the threshold values at codes +127, -127 and negative zero, the code change taking effect on the next sample, and the restart of the delay after a power-good dropout.

// File: rtl/trip_pkg.sv
// Package: trip_pkg
// Shared types for the threshold switch. The tracking phase tells the
// first decision after settling apart from the hysteretic decisions after it.
package trip_pkg;
    typedef enum logic {
        PH_FIRST = 1'b0,   // no decision taken yet since power-on
        PH_TRACK = 1'b1    // hysteretic tracking active
    } trk_phase_t;
endpackage

// File: rtl/trip_threshold_calc.sv
// Module: trip_threshold_calc
// Computes the operate and release thresholds from the signed code, with
// no clock. Assumes TW is wide enough that BASE +/- (2^CODE_W-1)*STEP - HYST
// cannot overflow.
module trip_threshold_calc #(
    parameter int CODE_W = 7,
    parameter int TW     = 29,
    parameter int BASE   = 1000,
    parameter int STEP   = 20,
    parameter int HYST   = 150
) (
    input  logic [CODE_W-1:0]    code_mag,
    input  logic                 code_neg,
    output logic signed [TW-1:0] operate_th,
    output logic signed [TW-1:0] release_th
);
    localparam logic signed [TW-1:0] BASE_T = TW'(BASE);
    localparam logic signed [TW-1:0] STEP_T = TW'(STEP);
    localparam logic signed [TW-1:0] HYST_T = TW'(HYST);

    logic signed [TW-1:0] mag_ext;
    logic signed [TW-1:0] code_val;

    // Widen the magnitude and apply the sign bit.
    always_comb begin
        mag_ext  = TW'({1'b0, code_mag});
        code_val = code_neg ? -mag_ext : mag_ext;
    end

    // Place the operate point, then the release point a fixed gap below it.
    always_comb begin
        operate_th = BASE_T + code_val * STEP_T;
        release_th = operate_th - HYST_T;
    end
endmodule

// File: rtl/trip_settle_timer.sv
// Module: trip_settle_timer
// Counts the clock edges with power good, up to SETTLE_CYC, and flags when
// the power-on delay is over. Reset or power-good loss clears the count.
module trip_settle_timer #(
    parameter int SETTLE_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    // Saturating count of the edges since power became good.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The delay is over once the count reaches its limit.
    always_comb settled = (cnt_q == LIMIT);
endmodule

// File: rtl/trip_decider.sv
// Module: trip_decider
// Holds the switch output. Before settling it is forced high. The first
// valid sample after settling sets it directly. Samples after that apply
// the operate/release hysteresis. Assumes thresholds and field share width TW.
module trip_decider
    import trip_pkg::*;
#(
    parameter int FW = 16,
    parameter int TW = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_good,
    input  logic                 settled,
    input  logic                 smp_vld,
    input  logic signed [FW-1:0] smp_field,
    input  logic signed [TW-1:0] operate_th,
    input  logic signed [TW-1:0] release_th,
    output logic                 out_level
);
    logic                 out_q, out_d;
    trk_phase_t           phase_q, phase_d;
    logic signed [TW-1:0] field_ext;
    logic                 above_op, below_rel;

    // Sign-extend the sample and compare it with both thresholds.
    always_comb begin
        field_ext = TW'(smp_field);
        above_op  = (field_ext >= operate_th);
        below_rel = (field_ext <  release_th);
    end

    // Next-state decision for a taken sample.
    always_comb begin
        out_d   = out_q;
        phase_d = phase_q;
        if (settled && smp_vld) begin
            if (above_op) begin
                out_d = 1'b0;
            end else if (phase_q == PH_FIRST || below_rel) begin
                out_d = 1'b1;
            end
            phase_d = PH_TRACK;
        end
    end

    // Output and phase registers; power-on state on reset or power loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            out_q   <= 1'b1;
            phase_q <= PH_FIRST;
        end else begin
            out_q   <= out_d;
            phase_q <= phase_d;
        end
    end

    assign out_level = out_q;
endmodule

// File: rtl/trip_switch.sv
// Module: trip_switch (top)
// Programmable threshold switch with a fixed hysteresis and a power-on
// settle delay. Assumes samples arrive as one-cycle strobes, at a rate
// far below the clock.
module trip_switch #(
    parameter int FW         = 16,
    parameter int CODE_W     = 7,
    parameter int BASE       = 1000,
    parameter int STEP       = 20,
    parameter int HYST       = 150,
    parameter int SETTLE_CYC = 12500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_good,
    input  logic                 smp_vld,
    input  logic signed [FW-1:0] smp_field,
    input  logic [CODE_W-1:0]    code_mag,
    input  logic                 code_neg,
    output logic                 out_level
);
    localparam int TW = FW + CODE_W + 6;

    logic signed [TW-1:0] operate_th;
    logic signed [TW-1:0] release_th;
    logic                 settled;

    trip_threshold_calc #(
        .CODE_W(CODE_W), .TW(TW), .BASE(BASE), .STEP(STEP), .HYST(HYST)
    ) u_calc (
        .code_mag  (code_mag),
        .code_neg  (code_neg),
        .operate_th(operate_th),
        .release_th(release_th)
    );

    trip_settle_timer #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_good(pwr_good),
        .settled (settled)
    );

    trip_decider #(
        .FW(FW), .TW(TW)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .settled   (settled),
        .smp_vld   (smp_vld),
        .smp_field (smp_field),
        .operate_th(operate_th),
        .release_th(release_th),
        .out_level (out_level)
    );
endmodule

// File: rtl/trip_switch_chk.sv
// Module: trip_switch_chk
// Property checker bound to trip_switch. It keeps its own count of the
// power-good edges so that the settle window can be checked without deep $past.
module trip_switch_chk #(
    parameter int FW         = 16,
    parameter int TW         = 29,
    parameter int HYST       = 150,
    parameter int SETTLE_CYC = 12500
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwr_good,
    input logic                 smp_vld,
    input logic signed [FW-1:0] smp_field,
    input logic                 settled,
    input logic signed [TW-1:0] operate_th,
    input logic signed [TW-1:0] release_th,
    input logic                 out_level
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0]        win_cnt;
    logic signed [TW-1:0] f_ext;
    logic                 take;

    // Independent count of the edges with power good since reset or dropout.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) win_cnt <= '0;
        else if (win_cnt != CW'(SETTLE_CYC)) win_cnt <= win_cnt + CW'(1);
    end

    // Widened sample and the condition under which it is taken.
    always_comb begin
        f_ext = TW'(smp_field);
        take  = pwr_good && settled && smp_vld;
    end

    a_r1_operate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (take && f_ext >= operate_th) |=> !out_level);

    a_r2_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (take && f_ext < release_th) |=> out_level);

    a_r3_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take && f_ext >= release_th && f_ext < operate_th) |=> $stable(out_level));

    // R5: fixed gap between the operate and release thresholds
    always_comb a_r5_fixed_gap: assert (operate_th - release_th == TW'(HYST));

    a_r6_settle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt < CW'(SETTLE_CYC)) |-> out_level);

    a_r8_pgood_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> out_level);

    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !smp_vld) |=> $stable(out_level));
endmodule

bind trip_switch trip_switch_chk #(
    .FW(FW), .TW(TW), .HYST(HYST), .SETTLE_CYC(SETTLE_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .smp_vld   (smp_vld),
    .smp_field (smp_field),
    .settled   (settled),
    .operate_th(operate_th),
    .release_th(release_th),
    .out_level (out_level)
);

// File: tb/test_trip_switch.sv
`timescale 1ns/1ps
// Directed bench for trip_switch. Each task runs one scenario and checks it.
module test_trip_switch;
    localparam int BASE   = 1000;
    localparam int STEP   = 20;
    localparam int HYST   = 150;
    localparam int SETTLE = 12500;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_good = 1'b0;
    logic              smp_vld = 1'b0;
    logic signed [15:0] smp_field = '0;
    logic [6:0]        code_mag = '0;
    logic              code_neg = 1'b0;
    logic              out_level;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    trip_switch i_trip_switch (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .smp_vld(smp_vld),
        .smp_field(smp_field), .code_mag(code_mag), .code_neg(code_neg),
        .out_level(out_level)
    );

    function automatic int op_of(input int mag, input bit neg);
        return BASE + (neg ? -mag : mag) * STEP;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: out_level=%b expected %b", req, act, exp);
        end
    endtask

    // Present one valid sample; return at the negedge after it is taken.
    task automatic send(input int f);
        @(negedge clk);
        smp_field = 16'(f);
        smp_vld   = 1'b1;
        @(negedge clk);
        smp_vld   = 1'b0;
    endtask

    task automatic set_code(input int mag, input bit neg);
        code_mag = 7'(mag);
        code_neg = neg;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset state", out_level, 1'b1);
        rst_n = 1'b1;
    endtask

    // Power up with a strong field held valid on every cycle.
    task automatic t_powerup_boundary();
        bit bad = 0;
        @(negedge clk);
        pwr_good = 1'b1;
        smp_field = 16'sd30000;
        smp_vld = 1'b1;
        for (int i = 1; i <= SETTLE; i++) begin
            @(negedge clk);
            if (out_level !== 1'b1) bad = 1;
        end
        chk("R6 high through settle window", bad ? 1'b0 : 1'b1, 1'b1);
        @(negedge clk);
        chk("R7 first taken sample above operate", out_level, 1'b0);
        smp_vld = 1'b0;
    endtask

    task automatic t_hyst_code0();
        set_code(0, 0);
        send(op_of(0, 0) - 100);
        chk("R3 in band keeps low", out_level, 1'b0);
        send(op_of(0, 0) - HYST - 1);
        chk("R2 below release", out_level, 1'b1);
        send(op_of(0, 0) - 1);
        chk("R3 in band keeps high", out_level, 1'b1);
        send(op_of(0, 0));
        chk("R1 at operate", out_level, 1'b0);
    endtask

    task automatic t_code_pos();
        set_code(127, 0);
        send(BASE);
        chk("R9 new code used by next sample", out_level, 1'b1);
        send(op_of(127, 0) - 1);
        chk("R4 +127 just below operate", out_level, 1'b1);
        send(op_of(127, 0));
        chk("R4 +127 at operate", out_level, 1'b0);
        send(op_of(127, 0) - HYST);
        chk("R5 +127 at release holds", out_level, 1'b0);
        send(op_of(127, 0) - HYST - 1);
        chk("R5 +127 below release", out_level, 1'b1);
    endtask

    task automatic t_code_neg();
        set_code(127, 1);
        send(op_of(127, 1));
        chk("R4 -127 at operate", out_level, 1'b0);
        send(op_of(127, 1) - HYST);
        chk("R5 -127 at release holds", out_level, 1'b0);
        send(op_of(127, 1) - HYST - 1);
        chk("R5 -127 below release", out_level, 1'b1);
        set_code(0, 1);
        send(BASE - 1);
        chk("R4 negative zero equals zero", out_level, 1'b1);
        send(BASE);
        chk("R4 negative zero at operate", out_level, 1'b0);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        smp_field = -16'sd30000;
        repeat (5) @(negedge clk);
        chk("R11 field ignored without strobe", out_level, 1'b0);
    endtask

    task automatic t_pgood_loss();
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R8 output high after power loss", out_level, 1'b1);
        pwr_good = 1'b1;
        set_code(0, 0);
        send(30000);
        chk("R8 delay restarted, sample ignored", out_level, 1'b1);
        repeat (SETTLE) @(negedge clk);
        send(op_of(0, 0) - 50);
        chk("R7 first sample in band gives high", out_level, 1'b1);
        send(op_of(0, 0));
        chk("R1 tracking after restart", out_level, 1'b0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset forces high", out_level, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_powerup_boundary();
        t_hyst_code0();
        t_code_pos();
        t_code_neg();
        t_no_strobe();
        t_pgood_loss();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule